// File: doc/BRIEF.md
# Postfix Boolean Equation Engine

This block runs a small user program of Boolean equations once for every scan request. The program is a list of 16-bit tokens in postfix order. It sits in a token memory that is written one word at a time. On a scan the engine steps through the list from address zero upward, one token per clock. Operand tokens push a bit onto a 32-entry operand stack. A gate token pops its inputs and pushes one result. An assignment token pops the finished value of an equation into a numbered virtual output. That assignment also closes the equation, so the next token starts a fresh one.

A bank of reset-dominant set/reset latches gives the program memory between scans. The latches are volatile: a reset clears them, and so does any change to the program. A program that breaks the token rules raises an error flag and aborts the scan. An aborted scan leaves the published virtual outputs and latch states exactly as the last good scan left them. A good scan publishes all its results together when it reaches its END token.

Top module: `bool_eqn_engine`

## Requirements
- R1: Token bits [15:12] hold the opcode and bits [11:0] hold the argument. The opcodes are: 0 END, 1 input operand (argument is the index into `in_bits`), 2 virtual-output operand (argument is 1..96), 3 AND with n inputs, 4 OR with n inputs, 5 NOT, 6 LATCH (argument is the latch index 0..15), 7 ASSIGN (argument is the virtual output 1..96). Virtual output k appears on `vo_out[k-1]`.
- R2: AND and OR with n from 1 to 16 combine the n topmost stack entries and push one result. NOT inverts the top entry. An n of 0 or above 16 is an error.
- R3: A virtual-output operand reads the value assigned earlier in the same scan. If the output has not yet been assigned in this scan, it reads the value published by the previous scan.
- R4: LATCH pops the reset bit from the top of the stack and the set bit from beneath it. Its new state is 0 when reset is 1, 1 when only set is 1, and unchanged otherwise. The new state is pushed onto the stack.
- R5: A reset clears the latches, `vo_out`, `scan_done` and `scan_err`. A write to the token memory or a pulse on `recompile` clears every latch.
- R6: ASSIGN requires exactly one entry on the stack. A deeper stack at ASSIGN is an error. After ASSIGN the stack is empty.
- R7: A second ASSIGN to the same virtual output within one scan is an error.
- R8: The stack holds 32 entries. A 33rd push is an error, and popping more entries than the stack holds is an error.
- R9: END with a non-empty stack is an error. A scan that reaches the last memory address without an END is an error.
- R10: An index out of range is an error: an input index of 32 or more, a virtual output outside 1..96, or a latch index of 16 or more. An opcode above 7 is also an error.
- R11: Any error aborts the scan. `scan_done` then pulses with `scan_err` at 1, and `vo_out` and the latches keep their previous values. A clean scan publishes all its assignments and latch states at its END token and pulses `scan_done` with `scan_err` at 0. `scan_err` holds its value until the next accepted scan starts.
- R12: The engine handles one token per clock. `scan_done` rises N cycles after the edge that accepts `scan_start`, where N is the number of tokens up to and including the token that ends the scan. A `scan_start` that arrives during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_we | input | 1 | Token memory write enable (also clears the latches) |
| tok_waddr | input | 6 | Token memory write address |
| tok_wdata | input | 16 | Token to write |
| recompile | input | 1 | Clears the latches without writing a token |
| in_bits | input | 32 | External input operands |
| scan_start | input | 1 | Starts a scan when the engine is idle |
| vo_out | output | 96 | Published virtual outputs |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| scan_err | output | 1 | Result flag of the last scan (1 = aborted) |

## Verification
The assertions assume that the token memory and `recompile` stay quiet while a scan runs. A write in mid-scan quietly abandons the scan with no done pulse, and no property covers that case. They also assume that `in_bits` holds steady from the accepting edge until `scan_done`. The stimulus writes every program while the engine is idle, changes the inputs only together with the start pulse, and waits for the done pulse before the next step. Only the latency test issues a second `scan_start` during a busy scan, to show that it is ignored.

// File: rtl/bool_eqn_pkg.sv
package bool_eqn_pkg;

  localparam int TOK_W    = 16;
  localparam int ARG_W    = 12;
  localparam int GATE_MAX = 16;
  localparam int FANIN_W  = $clog2(GATE_MAX + 1);

  typedef enum logic [3:0] {
    OP_END    = 4'd0,
    OP_IN     = 4'd1,
    OP_VO     = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_NOT    = 4'd5,
    OP_LATCH  = 4'd6,
    OP_ASSIGN = 4'd7
  } op_e;

  // Combine the n topmost stack bits; win[0] is the top of stack.
  function automatic logic gate_eval(input logic [GATE_MAX-1:0] win,
                                     input logic [FANIN_W-1:0]  n,
                                     input logic                is_or);
    logic acc;
    acc = !is_or;
    for (int k = 0; k < GATE_MAX; k++) begin
      if (k < int'(n)) acc = is_or ? (acc | win[k]) : (acc & win[k]);
    end
    return acc;
  endfunction

  // Reset-dominant latch update.
  function automatic logic latch_next(input logic set_b, input logic rst_b,
                                      input logic q);
    return !rst_b && (set_b || q);
  endfunction

endpackage

// File: rtl/eqn_token_mem.sv
module eqn_token_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/eqn_stack.sv
module eqn_stack #(
  parameter int DEPTH = 32,
  parameter int WIN   = 16,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IX_W  = $clog2(DEPTH),
  localparam int POP_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [POP_W-1:0] pop_n,
  input  logic             push,
  input  logic             push_bit,
  output logic [SP_W-1:0]  sp,
  output logic [WIN-1:0]   win
);

  logic [DEPTH-1:0] ent;
  logic [SP_W-1:0]  wr_pos;
  logic [SP_W-1:0]  sp_nxt;

  assign wr_pos = sp - SP_W'(pop_n);
  assign sp_nxt = wr_pos + SP_W'(push);

  // win[k] is the entry k places below the top; zero past the bottom.
  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      if (int'(sp) - 1 - k >= 0) win[k] = ent[IX_W'(int'(sp) - 1 - k)];
      else                       win[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= '0;
      ent <= '0;
    end else if (clr) begin
      sp <= '0;
    end else begin
      if (push && (int'(wr_pos) < DEPTH)) ent[wr_pos[IX_W-1:0]] <= push_bit;
      sp <= sp_nxt;
    end
  end

  // R8: the controller never pops below the bottom
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pop_n != '0) |-> (int'(pop_n) <= int'(sp)));

  // R8: the controller never pushes past the top
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (int'(sp) - int'(pop_n) + int'(push) <= DEPTH));

endmodule

// File: rtl/bool_eqn_engine.sv
module bool_eqn_engine
  import bool_eqn_pkg::*;
#(
  parameter int PROG_DEPTH  = 64,
  parameter int NUM_IN      = 32,
  parameter int NUM_VO      = 96,
  parameter int NUM_LATCH   = 16,
  parameter int STACK_DEPTH = 32,
  localparam int PA_W = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_we,
  input  logic [PA_W-1:0]   tok_waddr,
  input  logic [TOK_W-1:0]  tok_wdata,
  input  logic              recompile,
  input  logic [NUM_IN-1:0] in_bits,
  input  logic              scan_start,
  output logic [NUM_VO-1:0] vo_out,
  output logic              scan_done,
  output logic              scan_err
);

  localparam int SP_W    = $clog2(STACK_DEPTH + 1);
  localparam int IN_IX_W = $clog2(NUM_IN);
  localparam int VO_IX_W = $clog2(NUM_VO);
  localparam int LT_IX_W = $clog2(NUM_LATCH);
  localparam logic [ARG_W-1:0] A_NUM_IN = ARG_W'(NUM_IN);
  localparam logic [ARG_W-1:0] A_NUM_VO = ARG_W'(NUM_VO);
  localparam logic [ARG_W-1:0] A_NUM_LT = ARG_W'(NUM_LATCH);
  localparam logic [ARG_W-1:0] A_GMAX   = ARG_W'(GATE_MAX);

  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e                st;
  logic [PA_W-1:0]    pc;
  logic [TOK_W-1:0]   tok;
  logic [3:0]         op;
  logic [ARG_W-1:0]   arg;
  logic [NUM_VO-1:0]  vo_q, work, used;
  logic [NUM_LATCH-1:0] lat_q, lat_w;
  logic               done_q, err_q;

  logic [SP_W-1:0]     sp;
  logic [GATE_MAX-1:0] win;
  logic [ARG_W-1:0]    sp_a;

  // decode results
  logic               fault, finish, push, push_bit, vo_wr, lat_wr, q_new;
  logic [FANIN_W-1:0] pop_n;
  logic               vo_ok, sp_full, last_tok;
  logic [VO_IX_W-1:0] vo_ix;
  logic [LT_IX_W-1:0] lat_ix;

  // named internal events
  logic recompile_evt, start_evt, running, abort_evt, step_evt, commit_evt;
  logic vo_wr_evt, lat_wr_evt;

  eqn_token_mem #(.DEPTH(PROG_DEPTH), .WIDTH(TOK_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(tok_we), .waddr(tok_waddr),
    .wdata(tok_wdata), .raddr(pc), .rdata(tok)
  );

  logic [FANIN_W-1:0] stk_pop;
  logic               stk_push;

  eqn_stack #(.DEPTH(STACK_DEPTH), .WIN(GATE_MAX)) u_stack (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .pop_n(stk_pop),
    .push(stk_push), .push_bit(push_bit), .sp(sp), .win(win)
  );

  assign op      = tok[TOK_W-1 -: 4];
  assign arg     = tok[ARG_W-1:0];
  assign sp_a    = ARG_W'(sp);
  assign vo_ok   = (arg != '0) && (arg <= A_NUM_VO);
  assign vo_ix   = VO_IX_W'(arg - ARG_W'(1));
  assign lat_ix  = arg[LT_IX_W-1:0];
  assign sp_full = (int'(sp) == STACK_DEPTH);
  assign last_tok = (int'(pc) == PROG_DEPTH - 1);

  always_comb begin
    fault = 1'b0; finish = 1'b0; push = 1'b0; push_bit = 1'b0;
    vo_wr = 1'b0; lat_wr = 1'b0; pop_n = '0;
    q_new = latch_next(win[1], win[0], lat_w[lat_ix]);
    case (op)
      OP_END: begin
        if (sp != '0) fault = 1'b1;
        else          finish = 1'b1;
      end
      OP_IN: begin
        if (arg >= A_NUM_IN || sp_full) fault = 1'b1;
        else begin push = 1'b1; push_bit = in_bits[arg[IN_IX_W-1:0]]; end
      end
      OP_VO: begin
        if (!vo_ok || sp_full) fault = 1'b1;
        else begin push = 1'b1; push_bit = work[vo_ix]; end
      end
      OP_AND, OP_OR: begin
        if (arg == '0 || arg > A_GMAX || arg > sp_a) fault = 1'b1;
        else begin
          pop_n    = FANIN_W'(arg);
          push     = 1'b1;
          push_bit = gate_eval(win, FANIN_W'(arg), op == OP_OR);
        end
      end
      OP_NOT: begin
        if (sp == '0) fault = 1'b1;
        else begin pop_n = FANIN_W'(1); push = 1'b1; push_bit = !win[0]; end
      end
      OP_LATCH: begin
        if (arg >= A_NUM_LT || int'(sp) < 2) fault = 1'b1;
        else begin
          pop_n = FANIN_W'(2); push = 1'b1; push_bit = q_new; lat_wr = 1'b1;
        end
      end
      OP_ASSIGN: begin
        if (!vo_ok || int'(sp) != 1 || used[vo_ix]) fault = 1'b1;
        else begin pop_n = FANIN_W'(1); vo_wr = 1'b1; end
      end
      default: fault = 1'b1;
    endcase
  end

  assign recompile_evt = tok_we || recompile;
  assign start_evt  = scan_start && (st == S_IDLE) && !recompile_evt;
  assign running    = (st == S_RUN) && !recompile_evt;
  assign abort_evt  = running && (fault || (last_tok && !finish));
  assign commit_evt = running && !fault && finish;
  assign step_evt   = running && !abort_evt && !finish;
  assign vo_wr_evt  = step_evt && vo_wr;
  assign lat_wr_evt = step_evt && lat_wr;
  assign stk_pop    = step_evt ? pop_n : '0;
  assign stk_push   = step_evt && push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; vo_q <= '0; work <= '0; used <= '0;
      lat_q <= '0; lat_w <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (recompile_evt) begin
        lat_q <= '0;
        st    <= S_IDLE;
      end else if (start_evt) begin
        st <= S_RUN; pc <= '0; work <= vo_q; used <= '0;
        lat_w <= lat_q; err_q <= 1'b0;
      end else if (abort_evt) begin
        st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1;
      end else if (commit_evt) begin
        st <= S_IDLE; done_q <= 1'b1; vo_q <= work; lat_q <= lat_w;
      end else if (step_evt) begin
        pc <= pc + PA_W'(1);
        if (vo_wr_evt) begin
          work[vo_ix] <= win[0];
          used[vo_ix] <= 1'b1;
        end
        if (lat_wr_evt) lat_w[lat_ix] <= q_new;
      end
    end
  end

  assign vo_out    = vo_q;
  assign scan_done = done_q;
  assign scan_err  = err_q;

  // R12: done lasts exactly one cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  // R11: an aborted scan publishes nothing
  assert_vo_hold_on_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && scan_err) |-> $stable(vo_out));

  // R11: the error flag only rises together with done
  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_err) |-> scan_done);

  // R5: a recompile leaves every latch clear
  assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recompile_evt |=> (lat_q == '0));

  // R7: a written virtual output is marked as taken for the rest of the scan
  assert_assign_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vo_wr_evt |=> used[$past(vo_ix)]);

  // R12: the program counter advances by one per processed token
  assert_one_token_R12: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (pc == $past(pc) + PA_W'(1)));

endmodule

// File: tb/test_bool_eqn_engine.sv
module test_bool_eqn_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_we = 1'b0;
  logic [5:0]  tok_waddr = '0;
  logic [15:0] tok_wdata = '0;
  logic        recompile = 1'b0;
  logic [31:0] in_bits = '0;
  logic        scan_start = 1'b0;
  logic [95:0] vo_out;
  logic        scan_done, scan_err;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  logic [95:0] exp_vo = '0;

  always #2 clk = ~clk;  // 250 MHz

  bool_eqn_engine i_bool_eqn_engine (
    .clk(clk), .rst_n(rst_n), .tok_we(tok_we), .tok_waddr(tok_waddr),
    .tok_wdata(tok_wdata), .recompile(recompile), .in_bits(in_bits),
    .scan_start(scan_start), .vo_out(vo_out), .scan_done(scan_done),
    .scan_err(scan_err)
  );

  localparam logic [3:0] END = 4'd0, IN = 4'd1, VO = 4'd2, AND = 4'd3,
                         OR = 4'd4, NOT = 4'd5, LAT = 4'd6, ASG = 4'd7;

  // Vector table for the main program: inputs a..e in bits 0..4,
  // expected vo4..vo1 (vo1 = a&b, vo2 = ~c|vo1, vo3 = latch(d,e), vo4 = a|b|c).
  localparam logic [4:0] VEC_IN  [8] = '{5'b00000, 5'b00011, 5'b01100, 5'b00000,
                                         5'b11000, 5'b10000, 5'b01000, 5'b00100};
  localparam logic [3:0] VEC_EXP [8] = '{4'b0010, 4'b1011, 4'b1100, 4'b0110,
                                         4'b0010, 4'b0010, 4'b0110, 4'b1100};

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [3:0] op, input int arg);
    @(negedge clk);
    tok_we = 1'b1; tok_waddr = 6'(a); tok_wdata = {op, 12'(arg)};
    @(negedge clk);
    tok_we = 1'b0;
  endtask

  task automatic scan(input logic [31:0] inv, input int poke_at, output int cyc);
    @(negedge clk);
    in_bits = inv; scan_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    scan_start = 1'b0;
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      scan_start = (cyc == poke_at);
      if (scan_done) break;
    end
    scan_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int cyc;
    int a;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 reset vo", vo_out, '0);
    check("R5 reset done/err", {94'd0, scan_done, scan_err}, '0);
    rst_n = 1'b1;

    // main program (19 tokens)
    put(0, IN, 0);  put(1, IN, 1);  put(2, AND, 2); put(3, ASG, 1);
    put(4, IN, 2);  put(5, NOT, 0); put(6, VO, 1);  put(7, OR, 2);
    put(8, ASG, 2); put(9, IN, 3);  put(10, IN, 4); put(11, LAT, 0);
    put(12, ASG, 3); put(13, IN, 0); put(14, IN, 1); put(15, IN, 2);
    put(16, OR, 3); put(17, ASG, 4); put(18, END, 0);

    // R1 R2 R3 R4: walk the vector table
    for (int v = 0; v < 8; v++) begin
      scan({27'd0, VEC_IN[v]}, -1, cyc);
      exp_vo[3:0] = VEC_EXP[v];
      check("R2/R4 table vo", vo_out, exp_vo);
      check("R11 table err", {95'd0, scan_err}, '0);
    end

    // R5: rewriting a token clears the latch that was set
    put(18, END, 0);
    scan(32'd0, -1, cyc);
    exp_vo[3:0] = 4'b0010;
    check("R5 write clears latch", vo_out, exp_vo);

    // R12: latency and ignored start during a scan
    scan(32'b01000, 5, cyc);
    exp_vo[3:0] = 4'b0110;
    check("R12 latency", 96'(cyc), 96'd19);
    check("R4 set", vo_out, exp_vo);
    a = 0;
    repeat (30) begin @(negedge clk); if (scan_done) a++; end
    check("R12 busy start ignored", 96'(a), 96'd0);

    // R5: recompile strobe clears the latch
    @(negedge clk); recompile = 1'b1; @(negedge clk); recompile = 1'b0;
    scan(32'd0, -1, cyc);
    exp_vo[3:0] = 4'b0010;
    check("R5 strobe clears latch", vo_out, exp_vo);

    // R7 R11: double assignment aborts, outputs held
    put(0, IN, 0); put(1, ASG, 5); put(2, IN, 1); put(3, ASG, 5); put(4, END, 0);
    scan(32'd3, -1, cyc);
    check("R7 double assign err", {95'd0, scan_err}, 96'd1);
    check("R11 vo held", vo_out, exp_vo);

    // R11: clean scan after an error clears the flag
    put(2, END, 0);
    scan(32'd1, -1, cyc);
    exp_vo[4] = 1'b1;
    check("R11 err cleared", {95'd0, scan_err}, '0);
    check("R11 commit", vo_out, exp_vo);

    // R6: leftover at ASSIGN
    put(0, IN, 0); put(1, IN, 1); put(2, ASG, 7); put(3, END, 0);
    scan(32'd3, -1, cyc);
    check("R6 leftover at assign", {95'd0, scan_err}, 96'd1);
    check("R11 vo held R6", vo_out, exp_vo);

    // R9: leftover at END
    put(0, IN, 0); put(1, END, 0);
    scan(32'd1, -1, cyc);
    check("R9 leftover at end", {95'd0, scan_err}, 96'd1);

    // R8: underflow
    put(0, NOT, 0); put(1, END, 0);
    scan(32'd1, -1, cyc);
    check("R8 underflow", {95'd0, scan_err}, 96'd1);

    // R2: fan-in of 17 rejected
    for (int i = 0; i < 17; i++) put(i, IN, 0);
    put(17, AND, 17); put(18, ASG, 9); put(19, END, 0);
    scan(32'd1, -1, cyc);
    check("R2 fanin 17", {95'd0, scan_err}, 96'd1);

    // R8: exactly full stack is legal
    for (int i = 0; i < 32; i++) put(i, IN, 0);
    put(32, AND, 16); put(33, AND, 16); put(34, AND, 2); put(35, ASG, 8);
    put(36, END, 0);
    scan(32'd1, -1, cyc);
    exp_vo[7] = 1'b1;
    check("R8 full stack ok", {95'd0, scan_err}, '0);
    check("R8 full stack vo", vo_out, exp_vo);

    // R8: 33rd push overflows
    put(32, IN, 0); put(33, END, 0);
    scan(32'd1, -1, cyc);
    check("R8 overflow", {95'd0, scan_err}, 96'd1);

    // R2: AND of 16 distinct inputs
    for (int i = 0; i < 16; i++) put(i, IN, i);
    put(16, AND, 16); put(17, ASG, 10); put(18, END, 0);
    scan(32'h0000_FFFF, -1, cyc);
    exp_vo[9] = 1'b1;
    check("R2 and16 ones", vo_out, exp_vo);
    scan(32'h0000_7FFF, -1, cyc);
    exp_vo[9] = 1'b0;
    check("R2 and16 one zero", vo_out, exp_vo);

    // R3: operand reads previous scan's value before its assignment
    put(0, VO, 11); put(1, NOT, 0); put(2, ASG, 11); put(3, END, 0);
    scan(32'd0, -1, cyc);
    exp_vo[10] = 1'b1;
    check("R3 toggle 1", vo_out, exp_vo);
    scan(32'd0, -1, cyc);
    exp_vo[10] = 1'b0;
    check("R3 toggle 2", vo_out, exp_vo);

    // R10: bad indexes and opcode
    put(0, IN, 0); put(1, ASG, 0); put(2, END, 0);
    scan(32'd1, -1, cyc);
    check("R10 assign 0", {95'd0, scan_err}, 96'd1);
    put(0, VO, 97); put(1, ASG, 12);
    scan(32'd1, -1, cyc);
    check("R10 vo 97", {95'd0, scan_err}, 96'd1);
    put(0, IN, 32);
    scan(32'd1, -1, cyc);
    check("R10 in 32", {95'd0, scan_err}, 96'd1);
    put(0, IN, 0); put(1, IN, 0); put(2, LAT, 16); put(3, ASG, 12); put(4, END, 0);
    scan(32'd1, -1, cyc);
    check("R10 latch 16", {95'd0, scan_err}, 96'd1);
    put(0, 4'd9, 0);
    scan(32'd1, -1, cyc);
    check("R10 opcode 9", {95'd0, scan_err}, 96'd1);
    check("R11 vo held R10", vo_out, exp_vo);

    // R9: no END anywhere
    put(0, IN, 0);
    for (int i = 1; i < 64; i++) put(i, NOT, 0);
    scan(32'd1, -1, cyc);
    check("R9 missing end", {95'd0, scan_err}, 96'd1);
    check("R12 missing end latency", 96'(cyc), 96'd64);

    finish_run();
  end

endmodule